// File: doc/BRIEF.md
# Host Controller Control Register with Set and Clear Aliases

This block holds a 32-bit control word for a host controller. Software never writes the word directly. It writes a mask to one of two addresses. At the set address, every 1 in the mask turns the matching bit on. At the clear address, every 1 turns the matching bit off. A 0 in the mask leaves the matching bit as it was. Reading either address returns the whole word one cycle after the read strobe.

Each live bit follows its own rule:

- Some bits are plain set/clear bits.
- One bit can only be cleared. Its starting value comes from a nonvolatile configuration load.
- Two bits are interlocked with the link-enable bit.
- One bit requests a soft reset. It stays high until hardware reports that the reset is finished, and then clears itself.

The current values of the link-enable, link-power, posted-write-enable and soft-reset bits are driven out to the rest of the controller.

Top module: `ctrlPair`

## Requirements
- R1: A write at the set offset 0x50 sets every live bit whose mask bit is 1. Bits whose mask bit is 0 keep their value. The live bits are 30, 23, 22, 19, 18, 17 and 16, and each is further limited by R5 to R8.
- R2: A write at the clear offset 0x54 clears every live bit whose mask bit is 1 and leaves all other bits unchanged.
- R3: A read at offset 0x50 or 0x54 returns the word on busRData one cycle after the read strobe. A read at any other offset returns 0. busRData holds its value when no read is strobed.
- R4: Bits 31, 29–24, 21–20 and 15–0 always read 0, and writes to them have no effect.
- R5: Bit 23 loads cfgPhyProg at hardware reset. It can be cleared. A set-alias write to it is ignored. A soft reset leaves it unchanged.
- R6: Bit 22 changes only when bit 23 and bit 17 were both 1 before the write. Otherwise writes to it are ignored.
- R7: Bit 18 changes only while bit 17 is 0. Writes to it are ignored while bit 17 is 1.
- R8: Setting bit 16 starts a soft reset. From the next cycle and for as long as bit 16 is 1:
  - bits 22, 19, 18 and 17 read 0;
  - bit 30 equals cfgSwapOff;
  - writes to those bits are ignored;
  - a clear-alias write to bit 16 is ignored.
- R9: Bit 16 stays 1 until rstDone is sampled high, and reads 0 from the next cycle.
- R10: While rstN is low, bits 22 and 19–16 are 0, bit 30 equals cfgSwapOff and bit 23 equals cfgPhyProg.
- R11: linkEnOut, linkPwrOut, postWrOut and softRstReq always equal bits 17, 19, 18 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| busAddr | input | 8 | Register-bus byte offset |
| busWr | input | 1 | Single-cycle write strobe |
| busWData | input | 32 | Write mask |
| busRd | input | 1 | Single-cycle read strobe |
| busRData | output | 32 | Registered read data |
| cfgPhyProg | input | 1 | Nonvolatile initial value for bit 23 |
| cfgSwapOff | input | 1 | Configured reset value for bit 30 |
| rstDone | input | 1 | Hardware reports soft reset finished |
| softRstReq | output | 1 | Soft reset in progress (bit 16) |
| linkEnOut | output | 1 | Link enable (bit 17) |
| linkPwrOut | output | 1 | Link power status (bit 19) |
| postWrOut | output | 1 | Posted-write enable (bit 18) |

## Verification
The bench builds the block with the default 8-bit offset and offsets 0x50 and 0x54. This makes it cheap to:
- sweep a single-bit mask across all 32 positions at both aliases, starting from hardware resets under both configuration-input values;
- probe reads at neighbouring non-matching offsets.

It also steps through all 16 combinations of bits 23, 17, 18 and 22. Each combination covers the interlocks in one pass.

Soft reset is run with writes and a clear attempt made while it is in progress, and with the completion pulse held back for several cycles.

// File: rtl/ctrlPairPkg.sv
package ctrlPairPkg;
  localparam int unsigned REG_W = 32;
  localparam int BIT_SWAP = 30;
  localparam int BIT_PROG = 23;
  localparam int BIT_ENH  = 22;
  localparam int BIT_LPWR = 19;
  localparam int BIT_POST = 18;
  localparam int BIT_LINK = 17;
  localparam int BIT_SRST = 16;
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << BIT_SWAP) | (REG_W'(1) << BIT_PROG) | (REG_W'(1) << BIT_ENH) |
    (REG_W'(1) << BIT_LPWR) | (REG_W'(1) << BIT_POST) | (REG_W'(1) << BIT_LINK) |
    (REG_W'(1) << BIT_SRST);

  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             rdStb;
    logic             rdHit;
    logic             rstHold;
    logic             rstFinish;
  } ctlStb_t;
endpackage

// File: rtl/ctrlPairCtl.sv
module ctrlPairCtl
  import ctrlPairPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h50,
  parameter logic [ADDR_W-1:0] CLR_OFFS = 8'h54
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWData,
  input  logic              busRd,
  input  logic              softRstNow,
  input  logic              rstDone,
  output ctlStb_t           stb
);
  logic setHit, clrHit;

  always_comb begin
    setHit = busWr && (busAddr == SET_OFFS);
    clrHit = busWr && (busAddr == CLR_OFFS);
    stb.setMask   = setHit ? (busWData & LIVE_MASK) : '0;
    stb.clrMask   = clrHit ? (busWData & LIVE_MASK) : '0;
    stb.rdStb     = busRd;
    stb.rdHit     = (busAddr == SET_OFFS) || (busAddr == CLR_OFFS);
    // soft reset holds from the cycle it is requested
    stb.rstHold   = softRstNow || stb.setMask[BIT_SRST];
    stb.rstFinish = softRstNow && rstDone;
  end
endmodule

// File: rtl/ctrlPairData.sv
module ctrlPairData
  import ctrlPairPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic             cfgPhyProg,
  input  logic             cfgSwapOff,
  output logic [REG_W-1:0] regVal,
  output logic [REG_W-1:0] busRData
);
  logic [REG_W-1:0] regQ, regNxt, wrVal;

  always_comb begin
    wrVal  = (regQ | stb.setMask) & ~stb.clrMask;
    regNxt = regQ & LIVE_MASK;
    if (stb.rstHold) begin
      regNxt[BIT_SWAP] = cfgSwapOff;
      regNxt[BIT_ENH]  = 1'b0;
      regNxt[BIT_LPWR] = 1'b0;
      regNxt[BIT_POST] = 1'b0;
      regNxt[BIT_LINK] = 1'b0;
    end else begin
      regNxt[BIT_SWAP] = wrVal[BIT_SWAP];
      regNxt[BIT_LPWR] = wrVal[BIT_LPWR];
      regNxt[BIT_LINK] = wrVal[BIT_LINK];
      if (regQ[BIT_PROG] && regQ[BIT_LINK]) regNxt[BIT_ENH] = wrVal[BIT_ENH];
      if (!regQ[BIT_LINK]) regNxt[BIT_POST] = wrVal[BIT_POST];
    end
    regNxt[BIT_PROG] = regQ[BIT_PROG] && !stb.clrMask[BIT_PROG];
    if (regQ[BIT_SRST]) regNxt[BIT_SRST] = !stb.rstFinish;
    else                regNxt[BIT_SRST] = stb.setMask[BIT_SRST];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ           <= '0;
      regQ[BIT_SWAP] <= cfgSwapOff;
      regQ[BIT_PROG] <= cfgPhyProg;
      busRData       <= '0;
    end else begin
      regQ <= regNxt;
      if (stb.rdStb) busRData <= stb.rdHit ? regQ : '0;
    end
  end

  assign regVal = regQ;
endmodule

// File: rtl/ctrlPair.sv
module ctrlPair
  import ctrlPairPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h50,
  parameter logic [ADDR_W-1:0] CLR_OFFS = 8'h54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWData,
  input  logic              busRd,
  output logic [31:0]       busRData,
  input  logic              cfgPhyProg,
  input  logic              cfgSwapOff,
  input  logic              rstDone,
  output logic              softRstReq,
  output logic              linkEnOut,
  output logic              linkPwrOut,
  output logic              postWrOut
);
  ctlStb_t          stb;
  logic [REG_W-1:0] regVal;

  ctrlPairCtl #(.ADDR_W(ADDR_W), .SET_OFFS(SET_OFFS), .CLR_OFFS(CLR_OFFS)) uCtl (
    .busAddr(busAddr), .busWr(busWr), .busWData(busWData), .busRd(busRd),
    .softRstNow(regVal[BIT_SRST]), .rstDone(rstDone), .stb(stb)
  );

  ctrlPairData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgPhyProg(cfgPhyProg),
    .cfgSwapOff(cfgSwapOff), .regVal(regVal), .busRData(busRData)
  );

  assign softRstReq = regVal[BIT_SRST];
  assign linkEnOut  = regVal[BIT_LINK];
  assign linkPwrOut = regVal[BIT_LPWR];
  assign postWrOut  = regVal[BIT_POST];
endmodule

// File: rtl/ctrlPairChk.sv
module ctrlPairChk
  import ctrlPairPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h50
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [31:0]       busWData,
  input logic              busRd,
  input logic [31:0]       busRData,
  input logic              rstDone,
  input logic              softRstReq,
  input logic              linkEnOut,
  input logic              linkPwrOut,
  input logic              postWrOut
);
  logic rstStart;
  assign rstStart = busWr && (busAddr == SET_OFFS) &&
                    (|(busWData & (32'h1 << BIT_SRST)));

  p_rsvd_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRData & ~LIVE_MASK) == '0);
  p_soft_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    softRstReq |=> (!linkEnOut && !postWrOut && !linkPwrOut));
  p_soft_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (softRstReq && !rstDone) |=> softRstReq);
  p_soft_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (softRstReq && rstDone) |=> !softRstReq);
  p_post_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (linkEnOut && !softRstReq && !rstStart) |=> $stable(postWrOut));
  p_rd_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRData));
endmodule

bind ctrlPair ctrlPairChk #(.ADDR_W(ADDR_W), .SET_OFFS(SET_OFFS)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWData(busWData),
  .busRd(busRd), .busRData(busRData), .rstDone(rstDone), .softRstReq(softRstReq),
  .linkEnOut(linkEnOut), .linkPwrOut(linkPwrOut), .postWrOut(postWrOut)
);

// File: tb/sim_ctrlPair.sv
`timescale 1ns/1ps
module sim_ctrlPair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWData = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRData;
  logic        cfgPhyProg = 1'b0, cfgSwapOff = 1'b0, rstDone = 1'b0;
  logic        softRstReq, linkEnOut, linkPwrOut, postWrOut;

  int checks = 0, errors = 0;
  logic [31:0] expV;

  localparam logic [7:0]  SETA = 8'h50, CLRA = 8'h54;
  localparam logic [31:0] LIVE = 32'h40CF_0000;

  always #5 clk = ~clk;

  ctrlPair u0 (.*);

  function automatic logic [31:0] mdl(logic [31:0] cur, logic [31:0] sw, logic [31:0] cw,
                                      logic done, logic cfgS);
    logic [31:0] s, c, w, n;
    s = sw & LIVE; c = cw & LIVE; w = (cur | s) & ~c; n = cur;
    if (cur[16] || s[16]) begin
      n[30] = cfgS; n[22] = 1'b0; n[19:17] = 3'b000;
    end else begin
      n[30] = w[30]; n[19] = w[19]; n[17] = w[17];
      if (cur[23] && cur[17]) n[22] = w[22];
      if (!cur[17]) n[18] = w[18];
    end
    n[23] = cur[23] && !c[23];
    n[16] = cur[16] ? !done : s[16];
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwReset(logic p, logic s);
    @(negedge clk);
    rstN = 1'b0; cfgPhyProg = p; cfgSwapOff = s;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expV = '0; expV[30] = s; expV[23] = p;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busWData = '0;
    expV = mdl(expV, (a == SETA) ? d : 32'h0, (a == CLRA) ? d : 32'h0, 1'b0, cfgSwapOff);
  endtask

  task automatic rdChk(logic [7:0] a, string req);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
    check(req, busRData, ((a == SETA) || (a == CLRA)) ? expV : 32'h0);
    check("R11", {28'h0, softRstReq, linkEnOut, linkPwrOut, postWrOut},
          {28'h0, expV[16], expV[17], expV[19], expV[18]});
  endtask

  task automatic pulseDone();
    @(negedge clk);
    rstDone = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rstDone = 1'b0;
    expV = mdl(expV, 32'h0, 32'h0, 1'b1, cfgSwapOff);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state under both configuration patterns
    for (int k = 0; k < 4; k++) begin
      hwReset(k[0], k[1]);
      rdChk(SETA, "R10");
      rdChk(CLRA, "R10");
    end
    // R1 R2 R4 R5 sweep of single-bit masks over every position at both aliases
    for (int k = 0; k < 2; k++) begin
      hwReset(1'b1, k[0]);
      for (int b = 0; b < 32; b++) begin
        wr(SETA, 32'h1 << b);
        rdChk(SETA, (LIVE[b]) ? "R1" : "R4");
        if (expV[16]) begin
          pulseDone();
          rdChk(CLRA, "R9");
        end
      end
      for (int b = 0; b < 32; b++) begin
        wr(CLRA, 32'h1 << b);
        rdChk(CLRA, (LIVE[b]) ? "R2" : "R4");
      end
      // R5: bit 23 cannot be set back once cleared
      wr(SETA, 32'h0080_0000);
      rdChk(SETA, "R5");
    end
    // R3 read at other offsets gives zero; data held without strobe
    hwReset(1'b1, 1'b1);
    wr(SETA, 32'h000A_0000);
    rdChk(8'h4C, "R3");
    rdChk(8'h58, "R3");
    rdChk(8'h50, "R3");
    @(negedge clk); @(negedge clk);
    check("R3", busRData, expV);
    // R6 R7 interlocks over all combinations of bits 23, 17, 18, 22
    for (int k = 0; k < 16; k++) begin
      hwReset(k[0], 1'b0);
      if (k[2]) wr(SETA, 32'h0004_0000);
      if (k[1]) wr(SETA, 32'h0002_0000);
      if (k[3]) wr(SETA, 32'h0040_0000);
      rdChk(SETA, "R6");
      wr(SETA, 32'h0044_0000);
      rdChk(SETA, "R7");
      wr(CLRA, 32'h0044_0000);
      rdChk(CLRA, "R6");
    end
    // R8 R9 soft reset sequence
    hwReset(1'b1, 1'b0);
    wr(SETA, 32'h400C_0000);
    wr(SETA, 32'h0042_0000);
    rdChk(SETA, "R8");
    wr(SETA, 32'h0001_0000);
    rdChk(SETA, "R8");
    check("R5", {31'h0, expV[23]}, 32'h1);
    wr(SETA, 32'h400E_0000);
    rdChk(SETA, "R8");
    wr(CLRA, 32'h0001_0000);
    rdChk(CLRA, "R8");
    for (int i = 0; i < 5; i++) @(negedge clk);
    rdChk(SETA, "R9");
    pulseDone();
    rdChk(SETA, "R9");
    wr(SETA, 32'h0002_0000);
    rdChk(SETA, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule